// File: doc/BRIEF.md
# Programmable BCD Decade Down-Divider

This block is one decade of a down-counter meant for divide-by-n work, built as synchronous logic on a single system clock. Count requests arrive on two slow inputs of opposite polarity. Each input is synchronized and edge-detected inside the block, and a qualifying edge takes one step off the 4-bit state. The state runs through the digits nine down to zero. A preset word can be forced in while a level-sensitive load input is high. Presets above nine are accepted, and the counter works down from them in plain binary until it rejoins the decimal cycle.

A terminal-count flag marks the zero state. It is qualified by a cascade-feedback input, by the load input and by an internal arm bit. Feeding the flag back to the load input makes a divide-by-n stage. Wiring the flag of a more significant decade into the cascade input of a less significant one builds multi-digit dividers. An active-high master reset clears the state at once, without waiting for a clock. A separate active-low system reset is released in step with the clock.

Top module: `bcd_dn_div`

## Requirements
- R1: While mr is high, o reads 0000 and tc reads 0. This holds immediately, with no clock edge needed, and it overrides pl.
- R2: With mr low, at each clock edge where pl is high, o takes the value of p at that edge. Count requests seen while pl is high have no effect.
- R3: With pl low and cp1 low, a rising edge on cp0 lowers o by one. The new value shows from the third clock edge after the input change (SYNC_STAGES+1 edges).
- R4: With pl low and cp0 high, a falling edge on cp1 lowers o by one, with the same latency as R3.
- R5: These events leave o unchanged: a cp0 rise while cp1 is high, a cp1 fall while cp0 is low, a cp0 fall, and a cp1 rise. At most one step is taken per clock.
- R6: Decrement steps follow the decimal order 9, 8, ..., 1, 0 and then wrap from 0 back to 9.
- R7: A loaded value from 10 to 15 steps down by one in binary (15, 14, ..., 10) and then reaches 9.
- R8: tc is a register. After an edge, it is high only if o is 0000, cf was high and pl was low at that edge, and at least one step has occurred since the last load. A master or system reset counts as such a step.
- R9: With tc tied to pl and cf high, a preset n from 1 to 15 gives one tc pulse every n count requests, and a preset of 0 gives one every 10. Each tc pulse lasts exactly one clock.
- R10: Two decades can be chained. Both pl inputs take the low decade's tc, and the low decade's cf takes the high decade's tc. The high decade counts on the low decade entering 9. Presets (m, l) with l not 9 then give one tc per 10*m + l requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| mr | input | 1 | Asynchronous active-high master reset of the count |
| cp0 | input | 1 | Count request, rising-edge active while cp1 is low |
| cp1 | input | 1 | Count request, falling-edge active while cp0 is high |
| pl | input | 1 | Level-sensitive parallel load |
| p | input | 4 | Preset value |
| cf | input | 1 | Cascade feedback, qualifies tc |
| o | output | 4 | Current count state |
| tc | output | 1 | Registered terminal-count flag |

## Verification
The single-decade instance uses the default two-flop synchronizer. With it, the exact three-edge request latency of R3 and R4 can be sampled directly, and all sixteen presets are swept for the divide-by-n period. The two chained instances are built with SYNC_STAGES set to 3. This shows that the cascade, which includes the borrow from the low digit and the terminal decision qualified by cf, does not depend on the synchronizer depth when the request spacing is generous.

// File: rtl/bcd_div_pkg.sv
package bcd_div_pkg;

  localparam int DIGIT_W   = 4;
  localparam int DIGIT_TOP = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // One step down: zero wraps to the top digit, everything else drops by one
  function automatic digit_t digit_dec(input digit_t v);
    if (v == digit_t'(0)) begin
      return digit_t'(DIGIT_TOP);
    end
    return v - digit_t'(1);
  endfunction

endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sn = sh_q[STAGES-1];

endmodule

// File: rtl/bcd_req_edge.sv
module bcd_req_edge #(
  parameter int STAGES      = 2,
  parameter bit ACTIVE_RISE = 1'b1
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic req_i,
  output logic level_o,
  output logic hit_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], req_i};
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];

  generate
    if (ACTIVE_RISE) begin : g_rise
      assign hit_o = level_o & ~prev_q;
    end else begin : g_fall
      assign hit_o = ~level_o & prev_q;
    end
  endgenerate

endmodule

// File: rtl/bcd_digit_core.sv
module bcd_digit_core
  import bcd_div_pkg::*;
(
  input  logic   clk,
  input  logic   rst_sn,
  input  logic   mr,
  input  logic   pl,
  input  digit_t p,
  input  logic   cf,
  input  logic   step,
  output digit_t o,
  output logic   tc
);

  digit_t state_q, state_d;
  logic   armed_q, armed_d;
  logic   tc_q, tc_d;
  logic   state_en;

  // Next state: load wins over a step; a step re-arms the terminal flag
  always_comb begin
    state_d  = state_q;
    armed_d  = armed_q;
    state_en = 1'b0;
    if (pl) begin
      state_d  = p;
      armed_d  = 1'b0;
      state_en = 1'b1;
    end else if (step) begin
      state_d  = digit_dec(state_q);
      armed_d  = 1'b1;
      state_en = 1'b1;
    end
    tc_d = (state_d == digit_t'(0)) & armed_d & cf & ~pl;
  end

  always_ff @(posedge clk or negedge rst_sn or posedge mr) begin
    if (!rst_sn || mr) begin
      state_q <= '0;
      armed_q <= 1'b1;
      tc_q    <= 1'b0;
    end else begin
      if (state_en) begin
        state_q <= state_d;
        armed_q <= armed_d;
      end
      tc_q <= tc_d;
    end
  end

  assign o  = state_q;
  assign tc = tc_q;

  // R1
  mr_clear_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    mr |-> (o == digit_t'(0) && !tc));

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_sn || mr)
    pl |=> (o == $past(p)));

  // R6
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_sn || mr)
    (!pl && step) |=> (o == digit_dec($past(o))));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn || mr)
    (!pl && !step) |=> $stable(o));

  // R8
  tc_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    tc |-> (o == digit_t'(0)));

  // R8
  tc_load_chk: assert property (@(posedge clk) disable iff (!rst_sn || mr)
    pl |=> !tc);

endmodule

// File: rtl/bcd_dn_div.sv
module bcd_dn_div
  import bcd_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mr,
  input  logic               cp0,
  input  logic               cp1,
  input  logic               pl,
  input  logic [DIGIT_W-1:0] p,
  input  logic               cf,
  output logic [DIGIT_W-1:0] o,
  output logic               tc
);

  localparam int NUM_REQ = 2;

  logic               rst_sn;
  logic [NUM_REQ-1:0] req;
  logic [NUM_REQ-1:0] lvl;
  logic [NUM_REQ-1:0] hit;
  logic               step;

  assign req = {cp1, cp0};

  bcd_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // Line 0 triggers on a rising edge, line 1 on a falling edge
  for (genvar gi = 0; gi < NUM_REQ; gi++) begin : g_req
    bcd_req_edge #(
      .STAGES      (SYNC_STAGES),
      .ACTIVE_RISE (gi == 0)
    ) u_edge (
      .clk     (clk),
      .rst_sn  (rst_sn),
      .req_i   (req[gi]),
      .level_o (lvl[gi]),
      .hit_o   (hit[gi])
    );
  end

  // Each edge counts only while the other line sits at its enabling level
  always_comb begin
    step = ~pl & ((hit[0] & ~lvl[1]) | (hit[1] & lvl[0]));
  end

  bcd_digit_core u_core (
    .clk    (clk),
    .rst_sn (rst_sn),
    .mr     (mr),
    .pl     (pl),
    .p      (p),
    .cf     (cf),
    .step   (step),
    .o      (o),
    .tc     (tc)
  );

endmodule

// File: tb/bcd_dn_div_tb_top.sv
module bcd_dn_div_tb_top;

  logic       clk;
  logic       rst_n;
  logic       mr;
  logic       cp0;
  logic       cp1;
  logic       pl_drv;
  logic       fb;
  logic [3:0] p;
  logic       cf;
  logic [3:0] o;
  logic       tc;
  logic       pl_w;

  logic       c_mr;
  logic [3:0] c_p_l, c_p_m;
  logic [3:0] c_o_l, c_o_m;
  logic       c_tc_l, c_tc_m;
  logic       c_borrow;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int  d_rise, d_hi, c_rise;
  logic d_last, c_last;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign pl_w     = fb ? tc : pl_drv;
  assign c_borrow = (c_o_l == 4'd9);

  bcd_dn_div #(.SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .mr(mr), .cp0(cp0), .cp1(cp1),
    .pl(pl_w), .p(p), .cf(cf), .o(o), .tc(tc)
  );

  bcd_dn_div #(.SYNC_STAGES(3)) lsd_i (
    .clk(clk), .rst_n(rst_n), .mr(c_mr), .cp0(cp0), .cp1(cp1),
    .pl(c_tc_l), .p(c_p_l), .cf(c_tc_m), .o(c_o_l), .tc(c_tc_l)
  );

  bcd_dn_div #(.SYNC_STAGES(3)) msd_i (
    .clk(clk), .rst_n(rst_n), .mr(c_mr), .cp0(c_borrow), .cp1(1'b0),
    .pl(c_tc_l), .p(c_p_m), .cf(1'b1), .o(c_o_m), .tc(c_tc_m)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n);
    repeat (n) begin
      @(negedge clk);
      if (tc && !d_last) d_rise++;
      if (tc) d_hi++;
      d_last = tc;
      if (c_tc_l && !c_last) c_rise++;
      c_last = c_tc_l;
    end
  endtask

  task automatic pulse();
    cp0 = 1'b1;
    watch(4);
    cp0 = 1'b0;
    watch(4);
  endtask

  task automatic clear_watch();
    d_rise = 0; d_hi = 0; c_rise = 0;
    d_last = tc; c_last = c_tc_l;
  endtask

  task automatic t_reset();
    chk("R1 reset o", int'(o), 0);
    chk("R8 reset tc with cf low", int'(tc), 0);
  endtask

  task automatic t_mr_load();
    pl_drv = 1'b1; p = 4'd6;
    tick(2);
    chk("R2 load 6", int'(o), 6);
    mr = 1'b1;
    #1;
    chk("R1 async clear without edge", int'(o), 0);
    tick(2);
    chk("R1 overrides pl", int'(o), 0);
    chk("R1 tc low", int'(tc), 0);
    mr = 1'b0;
    tick(2);
    chk("R2 load after mr", int'(o), 6);
  endtask

  task automatic t_edges();
    pl_drv = 1'b1; p = 4'd7;
    tick(2);
    cp0 = 1'b1; tick(5);
    cp0 = 1'b0; tick(5);
    chk("R2 requests ignored under load", int'(o), 7);
    pl_drv = 1'b0; tick(2);
    cp1 = 1'b1; tick(5);
    chk("R5 cp1 rise", int'(o), 7);
    cp0 = 1'b1; tick(5);
    chk("R5 cp0 rise with cp1 high", int'(o), 7);
    cp1 = 1'b0; tick(2);
    chk("R4 not before third edge", int'(o), 7);
    tick(3);
    chk("R4 cp1 fall with cp0 high", int'(o), 6);
    cp0 = 1'b0; tick(5);
    chk("R5 cp0 fall", int'(o), 6);
    cp1 = 1'b1; tick(5);
    cp1 = 1'b0; tick(5);
    chk("R5 cp1 fall with cp0 low", int'(o), 6);
    cp0 = 1'b1; tick(3);
    chk("R3 cp0 rise with cp1 low", int'(o), 5);
    cp0 = 1'b0; tick(5);
  endtask

  task automatic t_sequence();
    int exp_seq[7] = '{4, 3, 2, 1, 0, 9, 8};
    foreach (exp_seq[i]) begin
      pulse();
      chk("R6 decimal step", int'(o), exp_seq[i]);
    end
  endtask

  task automatic t_high_preset();
    int exp_seq[7] = '{14, 13, 12, 11, 10, 9, 8};
    pl_drv = 1'b1; p = 4'd15;
    tick(2);
    pl_drv = 1'b0;
    tick(2);
    chk("R7 load 15", int'(o), 15);
    foreach (exp_seq[i]) begin
      pulse();
      chk("R7 binary step", int'(o), exp_seq[i]);
    end
  endtask

  task automatic t_tc_qual();
    cf = 1'b0;
    pl_drv = 1'b1; p = 4'd1;
    tick(2);
    pl_drv = 1'b0;
    pulse();
    chk("R8 zero reached", int'(o), 0);
    tick(3);
    chk("R8 tc low while cf low", int'(tc), 0);
    cf = 1'b1;
    tick(2);
    chk("R8 tc high with cf", int'(tc), 1);
    pl_drv = 1'b1;
    tick(1);
    chk("R8 tc drops under load", int'(tc), 0);
    p = 4'd0;
    tick(2);
    pl_drv = 1'b0;
    tick(4);
    chk("R8 no tc before a step after load", int'(tc), 0);
  endtask

  task automatic t_divide(input int n);
    int cnt;
    int want;
    want = (n == 0) ? 10 : n;
    p = 4'(n); cf = 1'b1; fb = 1'b1;
    mr = 1'b1; tick(1);
    mr = 1'b0; tick(3);
    chk("R9 self load", int'(o), n);
    clear_watch();
    for (int per = 0; per < 2; per++) begin
      cnt = 0;
      while (d_rise == per && cnt < 20) begin
        pulse();
        cnt++;
      end
      chk($sformatf("R9 divide period preset %0d", n), cnt, want);
    end
    chk($sformatf("R9 tc width preset %0d", n), d_hi, 2);
    fb = 1'b0;
  endtask

  task automatic t_chain(input int m, input int l, input int periods);
    int cnt;
    c_p_m = 4'(m); c_p_l = 4'(l);
    c_mr = 1'b1; tick(1);
    c_mr = 1'b0; tick(6);
    chk("R10 low digit loaded", int'(c_o_l), l);
    chk("R10 high digit loaded", int'(c_o_m), m);
    clear_watch();
    for (int per = 0; per < periods; per++) begin
      cnt = 0;
      while (c_rise == per && cnt < 200) begin
        pulse();
        cnt++;
      end
      chk($sformatf("R10 chain period %0d%0d", m, l), cnt, 10 * m + l);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mr = 1'b0; cp0 = 1'b0; cp1 = 1'b0;
    pl_drv = 1'b0; fb = 1'b0; p = 4'd0; cf = 1'b0;
    c_mr = 1'b1; c_p_l = 4'd0; c_p_m = 4'd0;
    d_rise = 0; d_hi = 0; c_rise = 0; d_last = 1'b0; c_last = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_mr_load();
    t_edges();
    t_sequence();
    t_high_preset();
    t_tc_qual();
    for (int n = 0; n < 16; n++) t_divide(n);
    mr = 1'b1;
    t_chain(2, 3, 2);
    t_chain(1, 0, 1);
    t_chain(1, 5, 1);
    finish_run();
  end

endmodule